// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block is a small data cache between a processor-side load/store port and a memory port that moves whole blocks. The processor presents a byte address, a read/write flag, a 32-bit write word and a per-byte lane mask. The controller takes one request at a time. It splits the address into a tag, a set index and a byte offset, and compares the tag against both ways of the selected set. A hit is answered without memory traffic. A miss first writes back the chosen victim if it holds modified data, then fetches the missing block. The request is then looked up again and completes as a hit. Reads and writes both allocate a line on a miss.

The default geometry is four lines of 32 bytes each, organised as two sets of two ways, with 16-bit addresses. Each line keeps a valid bit, a dirty bit and a 10-bit tag. Each set keeps one bit that names its least recently used way, and that way is the victim on a miss. A flush input walks every line and writes back each line that is dirty. It leaves the lines valid, clean and still able to hit, which lets a run hand a consistent memory image to the next consumer.

Top module: `wb_cache_ctrl`

## Requirements
- R1: After reset every line is invalid and clean and every replacement bit is zero. `cpuReady` is high and `memReq`, `cpuRspValid` and `flushDone` are low. A flush issued at that point moves no data, and the first access to any address refills a block.
- R2: Address bits [4:0] are the byte offset, bit [5] is the set and bits [15:6] are the tag. Every memory transaction carries a block-aligned address {tag, set, 5'b0}.
- R3: A read hit returns the 32-bit word at offset bits [4:2] of the addressed line with no memory transaction. `cpuRspValid` is a single-cycle pulse that carries `cpuRdata`.
- R4: A read miss fetches the enclosing block and then returns the addressed word from it.
- R5: A write miss fetches the enclosing block before the write is merged into it (write-allocate).
- R6: A write changes only the byte at line offset addr[4:2]*4+i for each lane i with `cpuByteEn[i]` set (lane 0 = bits 7:0 of `cpuWdata`). A write hit marks the line dirty.
- R7: When the victim line is valid and dirty, its block is written to memory before the refill read is issued, and the refill clears the dirty bit. A clean or invalid victim causes no write.
- R8: The victim in a set is the way that was accessed less recently in that set. Every completed lookup makes the hit way the most recent one.
- R9: A flush writes back each valid dirty line exactly once, clears its dirty bit and keeps it valid, then pulses `flushDone` for one cycle. A flush of a clean cache moves no data.
- R10: While `flushReq` is high in the idle state, `cpuReady` is low, so a flush raised in the same cycle as a request is served before that request.
- R11: `cpuReady` is high only in the idle state. From acceptance until after the response cycle, no further request is taken.
- R12: `memReq` stays high with a stable `memAddr` and `memWrite` until the cycle in which `memAck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request present |
| cpuReady | output | 1 | Controller idle and able to accept a request |
| cpuWrite | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 16 | Byte address |
| cpuWdata | input | 32 | Store word, lane i in bits 8i+7:8i |
| cpuByteEn | input | 4 | Store lane mask |
| cpuRspValid | output | 1 | One-cycle completion pulse |
| cpuRdata | output | 32 | Load word, valid with cpuRspValid |
| flushReq | input | 1 | Request to write back all dirty lines; held until flushDone |
| flushDone | output | 1 | One-cycle pulse at the end of a flush |
| memReq | output | 1 | Memory transaction request |
| memWrite | output | 1 | 1 = block write, 0 = block read |
| memAddr | output | 16 | Block-aligned memory address |
| memWdata | output | 256 | Block written to memory |
| memAck | input | 1 | One-cycle completion of the memory transaction |
| memRdata | input | 256 | Block read from memory, valid with memAck |

## Verification
A flush request and a processor store can arrive in the same cycle. The bench provokes this by raising `flushReq` and `cpuValid` on the same clock while one line is dirty. It then judges that `cpuReady` drops at once and that exactly one block write, to the dirty line's address, completes before `flushDone`. No response appears before that pulse, and the store is afterwards taken as a hit with no memory traffic. A second flush must then write back exactly the line the store dirtied, and a final comparison of the whole memory image against the bench's own model confirms that the store's data reached memory.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  localparam int WAYS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WRITEBACK,
    ST_REFILL,
    ST_RESPOND,
    ST_FLUSH
  } ctrlState_t;

  typedef enum logic [1:0] {
    MSEL_VICTIM,
    MSEL_FILL,
    MSEL_FLUSH
  } memSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    latchReq;
    logic    lookupAct;
    logic    victimClean;
    logic    fillLoad;
    logic    flushStart;
    logic    flushClean;
    logic    flushStep;
    memSel_t memSel;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic hit;
    logic victimDirty;
    logic flushDirty;
    logic flushLast;
  } dpStat_t;

endpackage

// File: rtl/wbc_datapath.sv
module wbc_datapath
  import wbc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 32,
  parameter int SETS        = 2,
  parameter int WORD_BYTES  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtrl_t                    ctl,
  output dpStat_t                    stat,
  input  logic [ADDR_W-1:0]          cpuAddr,
  input  logic                       cpuWrite,
  input  logic [WORD_BYTES*8-1:0]    cpuWdata,
  input  logic [WORD_BYTES-1:0]      cpuByteEn,
  output logic [WORD_BYTES*8-1:0]    cpuRdata,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [BLOCK_BYTES*8-1:0]   memWdata,
  input  logic [BLOCK_BYTES*8-1:0]   memRdata
);

  localparam int OFF_W   = $clog2(BLOCK_BYTES);
  localparam int SET_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - OFF_W - SET_W;
  localparam int BLOCK_W = BLOCK_BYTES * 8;
  localparam int WORD_W  = WORD_BYTES * 8;
  localparam int LANE_W  = $clog2(WORD_BYTES);
  localparam int WSEL_W  = OFF_W - LANE_W;
  localparam int WAY_W   = $clog2(WAYS);
  localparam int LINES   = SETS * WAYS;
  localparam int LIDX_W  = SET_W + WAY_W;

  // latched request
  logic [ADDR_W-1:LANE_W]  reqAddrQ;
  logic                    reqWriteQ;
  logic [WORD_W-1:0]       reqWdataQ;
  logic [WORD_BYTES-1:0]   reqBeQ;
  logic [LANE_W-1:0]       unusedLaneBits;

  // line storage
  logic [TAG_W-1:0]        tagQ   [SETS][WAYS];
  logic [BLOCK_W-1:0]      dataQ  [SETS][WAYS];
  logic [WAYS-1:0]         validQ [SETS];
  logic [WAYS-1:0]         dirtyQ [SETS];
  logic [SETS-1:0]         lruQ;
  logic [LIDX_W-1:0]       flushIdx;
  logic [WORD_W-1:0]       rdataQ;

  logic [TAG_W-1:0]        reqTag;
  logic [SET_W-1:0]        reqSet;
  logic [WSEL_W-1:0]       reqWsel;
  logic [WAYS-1:0]         wayHit;
  logic [WAY_W-1:0]        hitWay;
  logic [WAY_W-1:0]        victimWay;
  logic [SET_W-1:0]        flushSet;
  logic [WAY_W-1:0]        flushWay;
  logic [BLOCK_W-1:0]      hitLine;
  logic [BLOCK_W-1:0]      victimLine;
  logic [BLOCK_W-1:0]      mergedLine;

  assign unusedLaneBits = cpuAddr[LANE_W-1:0];

  assign reqTag  = reqAddrQ[ADDR_W-1 -: TAG_W];
  assign reqSet  = reqAddrQ[OFF_W +: SET_W];
  assign reqWsel = reqAddrQ[OFF_W-1:LANE_W];

  assign flushSet = flushIdx[LIDX_W-1 -: SET_W];
  assign flushWay = flushIdx[WAY_W-1:0];

  // tag compare, one per way
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wayHit[w] = validQ[reqSet][w] && (tagQ[reqSet][w] == reqTag);
  end

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (wayHit[w]) hitWay = WAY_W'(w);
  end

  assign victimWay  = lruQ[reqSet];
  assign hitLine    = dataQ[reqSet][hitWay];
  assign victimLine = dataQ[reqSet][victimWay];

  // byte-lane merge of the store word into the hit line
  always_comb begin
    mergedLine = hitLine;
    for (int b = 0; b < WORD_BYTES; b++)
      if (reqBeQ[b])
        mergedLine[(int'(reqWsel) * WORD_BYTES + b) * 8 +: 8] = reqWdataQ[b*8 +: 8];
  end

  assign stat.hit         = |wayHit;
  assign stat.victimDirty = validQ[reqSet][victimWay] && dirtyQ[reqSet][victimWay];
  assign stat.flushDirty  = validQ[flushSet][flushWay] && dirtyQ[flushSet][flushWay];
  assign stat.flushLast   = (flushIdx == LIDX_W'(LINES - 1));

  // request capture and read word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddrQ  <= '0;
      reqWriteQ <= 1'b0;
      reqWdataQ <= '0;
      reqBeQ    <= '0;
      rdataQ    <= '0;
    end else begin
      if (ctl.latchReq) begin
        reqAddrQ  <= cpuAddr[ADDR_W-1:LANE_W];
        reqWriteQ <= cpuWrite;
        reqWdataQ <= cpuWdata;
        reqBeQ    <= cpuByteEn;
      end
      if (ctl.lookupAct && stat.hit)
        rdataQ <= hitLine[int'(reqWsel) * WORD_W +: WORD_W];
    end
  end

  // line state bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        dirtyQ[s] <= '0;
      end
      lruQ     <= '0;
      flushIdx <= '0;
    end else begin
      if (ctl.lookupAct && stat.hit) begin
        lruQ[reqSet] <= ~hitWay;
        if (reqWriteQ) dirtyQ[reqSet][hitWay] <= 1'b1;
      end
      if (ctl.victimClean) dirtyQ[reqSet][victimWay] <= 1'b0;
      if (ctl.fillLoad) begin
        validQ[reqSet][victimWay] <= 1'b1;
        dirtyQ[reqSet][victimWay] <= 1'b0;
      end
      if (ctl.flushClean) dirtyQ[flushSet][flushWay] <= 1'b0;
      if (ctl.flushStart)     flushIdx <= '0;
      else if (ctl.flushStep) flushIdx <= flushIdx + 1'b1;
    end
  end

  // tag and data arrays
  always_ff @(posedge clk) begin
    if (ctl.lookupAct && stat.hit && reqWriteQ)
      dataQ[reqSet][hitWay] <= mergedLine;
    if (ctl.fillLoad) begin
      dataQ[reqSet][victimWay] <= memRdata;
      tagQ[reqSet][victimWay]  <= reqTag;
    end
  end

  // memory port steering
  always_comb begin
    unique case (ctl.memSel)
      MSEL_FILL: begin
        memAddr  = {reqTag, reqSet, {OFF_W{1'b0}}};
        memWdata = victimLine;
      end
      MSEL_FLUSH: begin
        memAddr  = {tagQ[flushSet][flushWay], flushSet, {OFF_W{1'b0}}};
        memWdata = dataQ[flushSet][flushWay];
      end
      default: begin
        memAddr  = {tagQ[reqSet][victimWay], reqSet, {OFF_W{1'b0}}};
        memWdata = victimLine;
      end
    endcase
  end

  assign cpuRdata = rdataQ;

endmodule

// File: rtl/wbc_control.sv
module wbc_control
  import wbc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuValid,
  input  logic    flushReq,
  input  logic    memAck,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    cpuReady,
  output logic    cpuRspValid,
  output logic    flushDone,
  output logic    memReq,
  output logic    memWrite
);

  ctrlState_t state, nextState;
  logic       lineDone;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    ctl         = '0;
    ctl.memSel  = MSEL_VICTIM;
    cpuReady    = 1'b0;
    cpuRspValid = 1'b0;
    flushDone   = 1'b0;
    memReq      = 1'b0;
    memWrite    = 1'b0;
    lineDone    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cpuReady = !flushReq;
        if (flushReq) begin
          ctl.flushStart = 1'b1;
          nextState      = ST_FLUSH;
        end else if (cpuValid) begin
          ctl.latchReq = 1'b1;
          nextState    = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (stat.hit) begin
          ctl.lookupAct = 1'b1;
          nextState     = ST_RESPOND;
        end else if (stat.victimDirty) begin
          nextState = ST_WRITEBACK;
        end else begin
          nextState = ST_REFILL;
        end
      end
      ST_WRITEBACK: begin
        memReq     = 1'b1;
        memWrite   = 1'b1;
        ctl.memSel = MSEL_VICTIM;
        if (memAck) begin
          ctl.victimClean = 1'b1;
          nextState       = ST_REFILL;
        end
      end
      ST_REFILL: begin
        memReq     = 1'b1;
        ctl.memSel = MSEL_FILL;
        if (memAck) begin
          ctl.fillLoad = 1'b1;
          nextState    = ST_LOOKUP;
        end
      end
      ST_RESPOND: begin
        cpuRspValid = 1'b1;
        nextState   = ST_IDLE;
      end
      ST_FLUSH: begin
        ctl.memSel = MSEL_FLUSH;
        if (stat.flushDirty) begin
          memReq   = 1'b1;
          memWrite = 1'b1;
          if (memAck) begin
            ctl.flushClean = 1'b1;
            lineDone       = 1'b1;
          end
        end else begin
          lineDone = 1'b1;
        end
        if (lineDone) begin
          if (stat.flushLast) begin
            flushDone = 1'b1;
            nextState = ST_IDLE;
          end else begin
            ctl.flushStep = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 32,
  parameter int SETS        = 2,
  parameter int WORD_BYTES  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cpuValid,
  output logic                      cpuReady,
  input  logic                      cpuWrite,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic [WORD_BYTES*8-1:0]   cpuWdata,
  input  logic [WORD_BYTES-1:0]     cpuByteEn,
  output logic                      cpuRspValid,
  output logic [WORD_BYTES*8-1:0]   cpuRdata,
  input  logic                      flushReq,
  output logic                      flushDone,
  output logic                      memReq,
  output logic                      memWrite,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [BLOCK_BYTES*8-1:0]  memWdata,
  input  logic                      memAck,
  input  logic [BLOCK_BYTES*8-1:0]  memRdata
);

  dpCtrl_t ctl;
  dpStat_t stat;

  wbc_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cpuValid    (cpuValid),
    .flushReq    (flushReq),
    .memAck      (memAck),
    .stat        (stat),
    .ctl         (ctl),
    .cpuReady    (cpuReady),
    .cpuRspValid (cpuRspValid),
    .flushDone   (flushDone),
    .memReq      (memReq),
    .memWrite    (memWrite)
  );

  wbc_datapath #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES),
    .SETS        (SETS),
    .WORD_BYTES  (WORD_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .stat      (stat),
    .cpuAddr   (cpuAddr),
    .cpuWrite  (cpuWrite),
    .cpuWdata  (cpuWdata),
    .cpuByteEn (cpuByteEn),
    .cpuRdata  (cpuRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memRdata  (memRdata)
  );

endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReady,
  input logic              cpuRspValid,
  input logic              flushReq,
  input logic              flushDone,
  input logic              memReq,
  input logic              memAck,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr
);

  localparam int OFF_W = $clog2(BLOCK_BYTES);

  AST_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[OFF_W-1:0] == '0)); // R2

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cpuRspValid |=> !cpuRspValid); // R3

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite))); // R12

  AST_FLUSH_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> !cpuReady); // R10

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> (!memReq && !cpuRspValid)); // R11

  AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |-> (!cpuRspValid && !cpuReady)); // R9

endmodule

bind wb_cache_ctrl wbc_checker #(
  .ADDR_W      (ADDR_W),
  .BLOCK_BYTES (BLOCK_BYTES)
) u_check (
  .clk         (clk),
  .rstN        (rstN),
  .cpuReady    (cpuReady),
  .cpuRspValid (cpuRspValid),
  .flushReq    (flushReq),
  .flushDone   (flushDone),
  .memReq      (memReq),
  .memAck      (memAck),
  .memWrite    (memWrite),
  .memAddr     (memAddr)
);

// File: tb/wb_cache_ctrl_test.sv
`timescale 1ns/1ps
module wb_cache_ctrl_test;

  localparam int ADDR_W  = 16;
  localparam int BLOCK_W = 256;
  localparam int NBLK    = 2048;

  typedef struct packed {
    logic        wr;
    logic        expWb;
    logic        expRf;
    logic [15:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
  } vec_t;

  // access trace with expected memory traffic per access
  localparam vec_t VECS [12] = '{
    '{1'b0, 1'b0, 1'b1, 16'h00a0, 32'h0,        4'h0},    // R1 R4 cold miss
    '{1'b1, 1'b0, 1'b1, 16'h00f4, 32'hA1B2C3D4, 4'hF},    // R5 write miss
    '{1'b0, 1'b0, 1'b0, 16'h00b0, 32'h0,        4'h0},    // R3 hit
    '{1'b1, 1'b1, 1'b1, 16'h2a2c, 32'h11223344, 4'b0110}, // R7 dirty victim
    '{1'b0, 1'b0, 1'b0, 16'h2a2c, 32'h0,        4'h0},    // R6 merged lanes
    '{1'b0, 1'b0, 1'b1, 16'h00f4, 32'h0,        4'h0},    // R8 LRU victim
    '{1'b0, 1'b0, 1'b1, 16'h0004, 32'h0,        4'h0},
    '{1'b1, 1'b0, 1'b1, 16'h0044, 32'hCAFEF00D, 4'b1000},
    '{1'b1, 1'b0, 1'b0, 16'h0008, 32'h5A5A5A5A, 4'b0001},
    '{1'b1, 1'b1, 1'b1, 16'h0084, 32'h01020304, 4'hF},
    '{1'b0, 1'b1, 1'b1, 16'h0048, 32'h0,        4'h0},
    '{1'b0, 1'b1, 1'b1, 16'h0008, 32'h0,        4'h0}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rstN = 1'b0;
  logic               cpuValid = 1'b0;
  logic               cpuReady;
  logic               cpuWrite = 1'b0;
  logic [15:0]        cpuAddr = '0;
  logic [31:0]        cpuWdata = '0;
  logic [3:0]         cpuByteEn = '0;
  logic               cpuRspValid;
  logic [31:0]        cpuRdata;
  logic               flushReq = 1'b0;
  logic               flushDone;
  logic               memReq;
  logic               memWrite;
  logic [15:0]        memAddr;
  logic [BLOCK_W-1:0] memWdata;
  logic               memAck = 1'b0;
  logic [BLOCK_W-1:0] memRdata = '0;

  wb_cache_ctrl uut (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuReady(cpuReady),
    .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuByteEn(cpuByteEn), .cpuRspValid(cpuRspValid), .cpuRdata(cpuRdata),
    .flushReq(flushReq), .flushDone(flushDone), .memReq(memReq),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  int checks = 0;
  int fails  = 0;

  function automatic logic [BLOCK_W-1:0] seedBlock(int idx);
    logic [BLOCK_W-1:0] r;
    for (int j = 0; j < 32; j++) r[j*8 +: 8] = 8'(idx * 37 + j * 11 + 5);
    return r;
  endfunction

  // memory model: ack two cycles after a request is seen
  logic [BLOCK_W-1:0] memStore [NBLK];
  bit                 memWritten [NBLK];
  int                 wbCount = 0;
  int                 rfCount = 0;
  int                 opCount = 0;
  int                 holdErr = 0;
  int                 lat = 0;
  logic [15:0]        opAddr [64];
  logic               opWr [64];
  logic [15:0]        startAddr = '0;
  logic               startWr = 1'b0;

  always @(negedge clk) begin
    if (memAck) begin
      memAck = 1'b0;
    end else if (memReq) begin
      if (lat == 0) begin
        startAddr = memAddr;
        startWr   = memWrite;
      end
      if (lat == 2) begin
        lat = 0;
        if (memAddr != startAddr || memWrite != startWr) holdErr++;
        opAddr[opCount % 64] = memAddr;
        opWr[opCount % 64]   = memWrite;
        opCount++;
        if (memWrite) begin
          memStore[memAddr[15:5]]   = memWdata;
          memWritten[memAddr[15:5]] = 1'b1;
          wbCount++;
        end else begin
          memRdata = memWritten[memAddr[15:5]] ? memStore[memAddr[15:5]]
                                               : seedBlock(int'(memAddr[15:5]));
          rfCount++;
        end
        memAck = 1'b1;
      end else begin
        lat++;
      end
    end
  end

  // processor-visible reference image
  logic [BLOCK_W-1:0] refMem [NBLK];

  function automatic logic [31:0] refWord(logic [15:0] a);
    return refMem[a[15:5]][int'(a[4:2]) * 32 +: 32];
  endfunction

  task automatic check(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic doReq(input logic wr, input logic [15:0] addr, input logic [31:0] wd,
                       input logic [3:0] be, output logic [31:0] rd);
    int guard;
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = addr; cpuWdata = wd; cpuByteEn = be;
    guard = 0;
    while (!cpuReady && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    cpuValid = 1'b0;
    check("R11 ready low after acceptance", cpuReady, 0);
    guard = 0;
    while (!cpuRspValid && guard < 1000) begin @(negedge clk); guard++; end
    check("R11 response arrives", guard < 1000, 1);
    rd = cpuRdata;
    if (wr)
      for (int b = 0; b < 4; b++)
        if (be[b]) refMem[addr[15:5]][(int'(addr[4:2]) * 4 + b) * 8 +: 8] = wd[b*8 +: 8];
  endtask

  task automatic doFlush(output int wbDelta);
    int w0;
    int guard;
    w0 = wbCount;
    @(negedge clk);
    flushReq = 1'b1;
    guard = 0;
    while (!flushDone && guard < 1000) begin @(negedge clk); guard++; end
    flushReq = 1'b0;
    check("R9 flush completes", guard < 1000, 1);
    wbDelta = wbCount - w0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual expired expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          d;
    int          guard;
    int          w0;
    int          r0;
    int          mism;
    bit          sawRsp;
    for (int i = 0; i < NBLK; i++) refMem[i] = seedBlock(i);

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cpuReady after reset", cpuReady, 1);
    check("R1 memReq after reset", memReq, 0);
    check("R1 cpuRspValid after reset", cpuRspValid, 0);
    check("R1 flushDone after reset", flushDone, 0);
    doFlush(d);
    check("R1 flush of empty cache moves nothing", d, 0);

    // table walk
    for (int i = 0; i < 12; i++) begin
      automatic vec_t        v   = VECS[i];
      automatic int          wb0 = wbCount;
      automatic int          rf0 = rfCount;
      automatic int          op0 = opCount;
      automatic logic [31:0] exp = refWord(v.addr);
      doReq(v.wr, v.addr, v.data, v.be, rd);
      if (!v.wr) begin
        if (v.expRf) check("R4 read miss data", rd, exp);
        else         check("R3 R6 read hit data", rd, exp);
      end
      check("R7 writeback count", wbCount - wb0, v.expWb);
      if (v.wr) check("R5 write-allocate refill count", rfCount - rf0, v.expRf);
      else      check("R8 refill count", rfCount - rf0, v.expRf);
      if (v.expRf)
        check("R2 refill block address", opAddr[(opCount - 1) % 64], {v.addr[15:5], 5'b0});
      if (v.expWb)
        check("R7 writeback before refill", {opWr[op0 % 64], opWr[(op0 + 1) % 64]}, 2'b10);
    end

    // flush and store raised in the same cycle
    w0 = wbCount; r0 = rfCount;
    @(negedge clk);
    flushReq = 1'b1;
    cpuValid = 1'b1; cpuWrite = 1'b1; cpuAddr = 16'h00e8;
    cpuWdata = 32'hDEADBEEF; cpuByteEn = 4'hF;
    #1;
    check("R10 ready low while flush pending", cpuReady, 0);
    guard = 0; sawRsp = 1'b0;
    while (!flushDone && guard < 1000) begin
      @(negedge clk);
      if (cpuRspValid) sawRsp = 1'b1;
      guard++;
    end
    flushReq = 1'b0;
    check("R10 no response before flushDone", sawRsp, 0);
    check("R9 flush writes one dirty line", wbCount - w0, 1);
    check("R9 flushed line address", opAddr[(opCount - 1) % 64], 16'h2a20);
    guard = 0;
    while (!cpuReady && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    cpuValid = 1'b0;
    guard = 0;
    while (!cpuRspValid && guard < 1000) begin @(negedge clk); guard++; end
    check("R10 store completes after flush", guard < 1000, 1);
    for (int b = 0; b < 4; b++) refMem[16'h00e8 >> 5][(2 * 4 + b) * 8 +: 8] = 8'(32'hDEADBEEF >> (b * 8));
    check("R6 store hit moves no data", (wbCount - w0) + (rfCount - r0), 1);

    doFlush(d);
    check("R9 second flush writes stored line", d, 1);
    check("R9 second flush address", opAddr[(opCount - 1) % 64], 16'h00e0);
    doFlush(d);
    check("R9 flush of clean cache moves nothing", d, 0);

    w0 = wbCount; r0 = rfCount;
    doReq(1'b0, 16'h2a2c, 32'h0, 4'h0, rd);
    check("R9 line stays valid after flush", (wbCount - w0) + (rfCount - r0), 0);
    check("R6 lanes after flush", rd, refWord(16'h2a2c));

    mism = 0;
    for (int i = 0; i < NBLK; i++)
      if ((memWritten[i] ? memStore[i] : seedBlock(i)) != refMem[i]) mism++;
    check("R7 memory image matches after flush", mism, 0);
    check("R12 request held until ack", holdErr, 0);

    summary();
    $finish;
  end

endmodule